// File: doc/BRIEF.md
# Four-Frame Multiframe Transmit Framer

This block builds the serial line stream for a 6312 kbit/s second-level digital link. Each frame is 789 bit slots long and four frames make one multiframe. In the first 784 slots of every frame the framer copies the caller's payload bit to the line. In the last five slots it inserts an overhead field that depends on the frame number. That field carries the alignment pattern, data link bits, a remote alarm bit, spare ones and a 5-bit CRC.

A one-cycle enable `bit_en` marks each line bit period, and the whole block advances one slot per enabled cycle. Before each enabled cycle the markers describe the slot that cycle will fill: `pay_req` asks for a payload bit, `frame_start` and `mframe_start` flag slot 1 of a frame and of a multiframe, and `frame_idx` gives the frame number. The bit chosen for that slot is registered and appears on `line_bit` after the enabled edge. The CRC covers every line bit from frame 1 slot 1 to frame 4 slot 784, so it includes the overhead already sent in frames 1 to 3. It is sent in the overhead of frame 4.

Top module: `mfr_tx_framer`

## Requirements
- R1: A frame is 789 enabled slots and a multiframe is four frames. `frame_start` is high for slot 1 of every frame. `mframe_start` is high only for slot 1 of frame 1. `frame_idx` counts 0,1,2,3 for frames 1 to 4.
- R2: `pay_req` is high for slots 1 to 784 and low for slots 785 to 789. In a payload slot, the `pay_bit` present at the enabled cycle becomes the line bit.
- R3: In frame 1 (frame_idx 0), slots 785 to 789 send 1, 1, 0, 0 and then the `link_bit` sampled in slot 789.
- R4: In frame 2 (frame_idx 1), slots 785 to 789 send 1, 0, 1, 0, 0.
- R5: In frame 3 (frame_idx 2), slots 785 to 787 send 1 (spare). Slot 788 sends `alarm_req` as sampled (1 = alarm). Slot 789 sends `link_bit` as sampled.
- R6: In frame 4 (frame_idx 3), slots 785 to 789 send the CRC remainder, most significant bit first. The remainder is taken over the 3151 line bits from frame 1 slot 1 to frame 4 slot 784, with generator x^5+x^4+x^2+1 and the register cleared at frame 1 slot 1. It equals the remainder of the message times x^5 divided by the generator.
- R7: In a cycle with `bit_en` low, no slot is consumed: `line_bit` and all markers hold their values.
- R8: `pay_bit` has no effect in overhead slots. `link_bit` and `alarm_req` have no effect outside their own overhead slots.
- R9: After reset the framer points at frame 1 slot 1 (`mframe_start`=1, `frame_start`=1, `pay_req`=1, `frame_idx`=0) and `line_bit` is 0.
- R10: `line_bit` is registered. After an enabled edge it carries the bit for the slot the markers described before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One line bit period per high cycle |
| pay_bit | input | 1 | Serial payload bit |
| link_bit | input | 1 | Data link bit, used in its overhead slots |
| alarm_req | input | 1 | Remote alarm request, used in its overhead slot |
| line_bit | output | 1 | Registered line bit |
| pay_req | output | 1 | Next slot takes a payload bit |
| frame_start | output | 1 | Next slot is slot 1 of a frame |
| mframe_start | output | 1 | Next slot is slot 1 of frame 1 |
| frame_idx | output | FRM_W (2) | Frame number of the next slot, 0 to 3 |

## Verification
The bench runs three whole multiframes with random payload, link and alarm values, so bits present in the wrong slot change the line. It predicts the CRC by polynomial long division over the line bits it expects, overhead included. A framer that left the earlier overhead out of the CRC, did not clear it at frame 1, or sent e5 first would miscompare in frame 4. Random idle gaps between enables catch a design that advances or changes its output without `bit_en`. Multiframes with the alarm set and cleared catch a swapped or fixed alarm slot. An off-by-one in the 789-slot count would shift every later overhead field and the marker checks.

// File: rtl/mfr_pkg.sv
package mfr_pkg;

    typedef enum logic [2:0] {
        SL_PAY   = 3'd0,
        SL_ONE   = 3'd1,
        SL_ZERO  = 3'd2,
        SL_LINK  = 3'd3,
        SL_ALARM = 3'd4,
        SL_CRC   = 3'd5
    } slot_e;

endpackage

// File: rtl/mfr_slot_counter.sv
module mfr_slot_counter #(
    parameter int FRAME_LEN = 789,
    parameter int FRAMES    = 4,
    localparam int POS_W    = $clog2(FRAME_LEN),
    localparam int FRM_W    = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos,
    output logic [FRM_W-1:0] frm
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic [FRM_W-1:0] frm;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step) begin
            if (cnt_q.pos == POS_W'(FRAME_LEN - 1)) begin
                cnt_d.pos = '0;
                if (cnt_q.frm == FRM_W'(FRAMES - 1)) begin
                    cnt_d.frm = '0;
                end else begin
                    cnt_d.frm = cnt_q.frm + 1'b1;
                end
            end else begin
                cnt_d.pos = cnt_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pos = cnt_q.pos;
    assign frm = cnt_q.frm;

endmodule

// File: rtl/mfr_slot_decode.sv
module mfr_slot_decode
    import mfr_pkg::*;
#(
    parameter int FRAME_LEN = 789,
    parameter int OH_LEN    = 5,
    parameter int FRAMES    = 4,
    localparam int PAY_LEN  = FRAME_LEN - OH_LEN,
    localparam int POS_W    = $clog2(FRAME_LEN),
    localparam int FRM_W    = $clog2(FRAMES)
) (
    input  logic [POS_W-1:0] pos,
    input  logic [FRM_W-1:0] frm,
    output slot_e            kind,
    output logic             span_first,
    output logic             span_last
);

    logic [POS_W-1:0] rel;

    assign rel        = pos - POS_W'(PAY_LEN);
    assign span_first = (pos == '0) && (frm == '0);
    assign span_last  = (pos == POS_W'(PAY_LEN - 1)) && (frm == FRM_W'(FRAMES - 1));

    always_comb begin
        kind = SL_PAY;
        if (pos >= POS_W'(PAY_LEN)) begin
            if (frm == FRM_W'(0)) begin
                if (rel == POS_W'(0) || rel == POS_W'(1)) begin
                    kind = SL_ONE;
                end else if (rel == POS_W'(4)) begin
                    kind = SL_LINK;
                end else begin
                    kind = SL_ZERO;
                end
            end else if (frm == FRM_W'(1)) begin
                if (rel == POS_W'(0) || rel == POS_W'(2)) begin
                    kind = SL_ONE;
                end else begin
                    kind = SL_ZERO;
                end
            end else if (frm == FRM_W'(2)) begin
                if (rel == POS_W'(3)) begin
                    kind = SL_ALARM;
                end else if (rel == POS_W'(4)) begin
                    kind = SL_LINK;
                end else begin
                    kind = SL_ONE;
                end
            end else begin
                kind = SL_CRC;
            end
        end
    end

endmodule

// File: rtl/mfr_crc_gen.sv
module mfr_crc_gen #(
    parameter int               CRC_W    = 5,
    parameter logic [CRC_W-1:0] CRC_POLY = 5'h15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    input  logic din,
    input  logic latch,
    input  logic shift,
    output logic msb
);

    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] rem;
    } crc_t;

    crc_t             crc_d, crc_q;
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] nxt;
    logic             fb;

    always_comb begin
        base  = clear ? '0 : crc_q.acc;
        fb    = din ^ base[CRC_W-1];
        nxt   = {base[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        crc_d = crc_q;
        if (step) begin
            crc_d.acc = nxt;
            if (latch) begin
                crc_d.rem = nxt;
            end else if (shift) begin
                crc_d.rem = {crc_q.rem[CRC_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign msb = crc_q.rem[CRC_W-1];

endmodule

// File: rtl/mfr_tx_framer.sv
module mfr_tx_framer
    import mfr_pkg::*;
#(
    parameter int               FRAME_LEN = 789,
    parameter int               OH_LEN    = 5,
    parameter int               FRAMES    = 4,
    parameter int               CRC_W     = 5,
    parameter logic [CRC_W-1:0] CRC_POLY  = 5'h15,
    localparam int              POS_W     = $clog2(FRAME_LEN),
    localparam int              FRM_W     = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             pay_bit,
    input  logic             link_bit,
    input  logic             alarm_req,
    output logic             line_bit,
    output logic             pay_req,
    output logic             frame_start,
    output logic             mframe_start,
    output logic [FRM_W-1:0] frame_idx
);

    logic [POS_W-1:0] pos;
    logic [FRM_W-1:0] frm;
    slot_e            kind;
    logic             span_first;
    logic             span_last;
    logic             crc_msb;
    logic             slot_bit;
    logic             line_d, line_q;

    mfr_slot_counter #(
        .FRAME_LEN(FRAME_LEN),
        .FRAMES   (FRAMES)
    ) cnt_i (
        .clk  (clk),
        .rst_n(rst_n),
        .step (bit_en),
        .pos  (pos),
        .frm  (frm)
    );

    mfr_slot_decode #(
        .FRAME_LEN(FRAME_LEN),
        .OH_LEN   (OH_LEN),
        .FRAMES   (FRAMES)
    ) dec_i (
        .pos       (pos),
        .frm       (frm),
        .kind      (kind),
        .span_first(span_first),
        .span_last (span_last)
    );

    always_comb begin
        unique case (kind)
            SL_PAY:   slot_bit = pay_bit;
            SL_ONE:   slot_bit = 1'b1;
            SL_ZERO:  slot_bit = 1'b0;
            SL_LINK:  slot_bit = link_bit;
            SL_ALARM: slot_bit = alarm_req;
            SL_CRC:   slot_bit = crc_msb;
            default:  slot_bit = 1'b1;
        endcase
    end

    mfr_crc_gen #(
        .CRC_W   (CRC_W),
        .CRC_POLY(CRC_POLY)
    ) crc_i (
        .clk  (clk),
        .rst_n(rst_n),
        .step (bit_en),
        .clear(span_first),
        .din  (slot_bit),
        .latch(span_last),
        .shift(kind == SL_CRC),
        .msb  (crc_msb)
    );

    always_comb begin
        line_d = line_q;
        if (bit_en) begin
            line_d = slot_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= 1'b0;
        end else begin
            line_q <= line_d;
        end
    end

    assign line_bit     = line_q;
    assign pay_req      = (kind == SL_PAY);
    assign frame_start  = (pos == '0);
    assign mframe_start = span_first;
    assign frame_idx    = frm;

endmodule

// File: rtl/mfr_tx_framer_chk.sv
module mfr_tx_framer_chk #(
    parameter int FRM_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_en,
    input logic             pay_bit,
    input logic             line_bit,
    input logic             pay_req,
    input logic             frame_start,
    input logic             mframe_start,
    input logic [FRM_W-1:0] frame_idx
);

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_bit) && $stable(pay_req) && $stable(frame_idx)
                    && $stable(frame_start));

    a_r1_mf_start_in_frame1: assert property (@(posedge clk) disable iff (!rst_n)
        mframe_start |-> frame_start && (frame_idx == '0));

    a_r2_payload_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && pay_req |=> line_bit == $past(pay_bit));

    a_r2_start_is_payload: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> pay_req);

    a_r1_start_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && frame_start |=> !frame_start);

    a_r1_idx_steady_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && pay_req |=> $stable(frame_idx));

endmodule

bind mfr_tx_framer mfr_tx_framer_chk #(.FRM_W(FRM_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .pay_bit     (pay_bit),
    .line_bit    (line_bit),
    .pay_req     (pay_req),
    .frame_start (frame_start),
    .mframe_start(mframe_start),
    .frame_idx   (frame_idx)
);

// File: tb/mfr_tx_framer_tb_top.sv
module mfr_tx_framer_tb_top;

    localparam int FLEN  = 789;
    localparam int PLEN  = 784;
    localparam int NFRM  = 4;
    localparam int MSGN  = 3151;
    localparam int CLK_P = 20;

    typedef struct {
        logic  bitv;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       pay_bit = 1'b0;
    logic       link_bit = 1'b0;
    logic       alarm_req = 1'b0;
    logic       line_bit;
    logic       pay_req;
    logic       frame_start;
    logic       mframe_start;
    logic [1:0] frame_idx;

    int   checks = 0;
    int   errors = 0;
    logic en_seen = 1'b0;
    exp_t sb_q[$];
    logic msg[MSGN];
    logic [4:0] crc_exp;
    int   bf = 0;
    int   bp = 0;
    logic last_exp = 1'b0;
    bit   finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mfr_tx_framer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .pay_bit     (pay_bit),
        .link_bit    (link_bit),
        .alarm_req   (alarm_req),
        .line_bit    (line_bit),
        .pay_req     (pay_req),
        .frame_start (frame_start),
        .mframe_start(mframe_start),
        .frame_idx   (frame_idx)
    );

    task automatic check(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b (frame %0d slot %0d)",
                     tag, act, expv, bf + 1, bp + 1);
        end
    endtask

    function automatic logic [4:0] long_div();
        logic [4:0] r = '0;
        for (int i = 0; i < MSGN + 5; i++) begin
            logic [5:0] v;
            v = {r, (i < MSGN) ? msg[i] : 1'b0};
            if (v[5]) v = v ^ 6'b110101;
            r = v[4:0];
        end
        return r;
    endfunction

    always @(posedge clk) en_seen <= bit_en && rst_n;

    always @(negedge clk) begin
        if (en_seen) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10: actual line bit with no expected entry, expected none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(line_bit, e.bitv, e.tag);
            end
        end
    end

    task automatic step(input int gap, input logic alarm_val);
        logic  pb, lb, ab, e;
        string tag;
        int    off;
        check(pay_req, logic'(bp < PLEN), "R2 pay_req");
        check(frame_start, logic'(bp == 0), "R1 frame_start");
        check(mframe_start, logic'(bp == 0 && bf == 0), "R1 mframe_start");
        check(frame_idx[0], logic'(bf % 2), "R1 frame_idx[0]");
        check(frame_idx[1], logic'(bf / 2), "R1 frame_idx[1]");
        pb = 1'($urandom);
        lb = 1'($urandom);
        ab = 1'($urandom);
        off = bp - PLEN;
        if (bp < PLEN) begin
            e = pb; tag = "R2 payload";
        end else if (bf == 0) begin
            e = (off < 2) ? 1'b1 : (off == 4) ? lb : 1'b0;
            tag = "R3 frame1 overhead (R8)";
        end else if (bf == 1) begin
            e = (off == 0 || off == 2); tag = "R4 frame2 overhead";
        end else if (bf == 2) begin
            if (off == 3) ab = alarm_val;
            e = (off < 3) ? 1'b1 : (off == 3) ? ab : lb;
            tag = "R5 frame3 overhead (R8)";
        end else begin
            e = crc_exp[4 - off]; tag = "R6 crc bit";
        end
        if (bf < 3 || bp < PLEN) msg[bf * FLEN + bp] = e;
        if (bf == 3 && bp == PLEN - 1) crc_exp = long_div();
        sb_q.push_back('{e, tag});
        pay_bit   = pb;
        link_bit  = lb;
        alarm_req = ab;
        bit_en    = 1'b1;
        @(negedge clk);
        bit_en    = 1'b0;
        pay_bit   = 1'($urandom);
        link_bit  = 1'($urandom);
        alarm_req = 1'($urandom);
        last_exp  = e;
        if (bp == FLEN - 1) begin
            bp = 0;
            bf = (bf + 1) % NFRM;
        end else begin
            bp++;
        end
        if (gap > 0) begin
            repeat (gap) @(negedge clk);
            check(line_bit, last_exp, "R7 hold while idle");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_bit, 1'b0, "R9 reset line_bit");
        check(mframe_start, 1'b1, "R9 reset mframe_start");
        check(pay_req, 1'b1, "R9 reset pay_req");
        check(logic'(frame_idx == 2'd0), 1'b1, "R9 reset frame_idx");
        for (int mf = 0; mf < 3; mf++) begin
            for (int s = 0; s < FLEN * NFRM; s++) begin
                step(($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0, logic'(mf % 2));
            end
        end
        repeat (2) @(negedge clk);
        check(logic'(sb_q.size() == 0), 1'b1, "R10 all expected bits seen");
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule